// File: doc/BRIEF.md
# Modem Handshake Control and Status Register

This block holds the modem control register and the modem status register of a 16550-style serial port. Four incoming handshake lines (clear-to-send, data-set-ready, carrier-detect and ring) are passed through a synchronizer. Their current levels appear in the upper half of the status byte. The lower half holds sticky change flags. Any pending change flag raises a modem-status interrupt request when the interrupt enable is set. The control register drives the request-to-send, terminal-ready and two general-purpose outputs. A loop bit in the control register turns the status read into a view of the control outputs.

The host side is a plain write strobe with data for the control register and a read strobe for the status register. The status byte is always presented on `stat_rdata`. A read strobe marks the cycle in which software consumes it, so the change flags are cleared on the following edge. Address decoding and interrupt prioritisation are handled outside this block.

Top module: `mdm_ctl_status`

## Requirements
- R1: After reset the control register reads 0x08 (OUT2 set only), `out2_o` is 1 and `rts_o`, `dtr_o` and `out1_o` are 0. The status byte reads 0xB0 and `irq` is 0.
- R2: A control write stores only data bits 4:0 and returns zeros in bits 7:5. Bit 0 drives `dtr_o`, bit 1 drives `rts_o`, bit 2 drives `out1_o`, bit 3 drives `out2_o` and bit 4 selects loopback.
- R3: Status bits 7, 6, 5 and 4 show carrier-detect, ring, data-set-ready and clear-to-send. A line change becomes visible on the third rising clock edge after it is applied, because of a two-stage synchronizer.
- R4: Any change of clear-to-send sets bit 0, of data-set-ready sets bit 1, and of carrier-detect sets bit 3. Each flag stays set until it is cleared by a read.
- R5: Bit 2 is set only when ring falls from 1 to 0. A rising ring edge leaves it clear.
- R6: A status read strobe outside loopback returns the current byte and clears bits 3:0 on the next edge. A change detected in that same cycle is kept.
- R7: `irq` is 1 exactly when `irq_en` is 1 and at least one of the stored change flags is set.
- R8: In loopback the status byte reads OUT2 on bit 7, OUT1 on bit 6, DTR on bit 5 and RTS on bit 4, with bits 3:0 reading zero. `rts_o` and `dtr_o` are held at 0 in loopback. A read strobe in loopback does not clear the stored change flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register value |
| stat_rd | input | 1 | Status read strobe (clears change flags) |
| stat_rdata | output | 8 | Status byte |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |
| cts_i | input | 1 | Clear-to-send line (asynchronous) |
| dsr_i | input | 1 | Data-set-ready line (asynchronous) |
| dcd_i | input | 1 | Carrier-detect line (asynchronous) |
| ri_i | input | 1 | Ring line (asynchronous) |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Terminal-ready output |
| out1_o | output | 1 | General-purpose output 1 |
| out2_o | output | 1 | General-purpose output 2 |

## Verification
The assertions check the following on every cycle:
- the control write mask;
- the stickiness of the change flags;
- that a rising ring edge never creates the trailing-edge flag;
- that a read with no concurrent change empties the flags;
- the relation between `irq`, its enable and the visible flags;
- that the handshake outputs stay low in loopback.

Some behaviours can only be shown by the bench scenarios:
- the exact three-edge latency of a line change;
- the full loopback bit remapping;
- survival of a change that lands in the same cycle as a read;
- survival of flags across a loopback read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int LINE_N = 4;
    localparam int CTL_W  = 5;

    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;

    // ordered to match status byte bits 7:4
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mdm_lines_t;

    localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [LAST:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[LAST-1:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[LAST];
    end
endmodule

// File: rtl/mdm_ctl.sv
module mdm_ctl #(
    parameter int W = 5,
    parameter logic [W-1:0] RST_VAL = 5'h08
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [7:0]   wdata_i,
    output logic [W-1:0] ctl_o
);
    logic [W-1:0] ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_i) ctl_d = wdata_i[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= RST_VAL;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  mdm_lines_t lines_i,
    input  logic       clr_i,
    output mdm_lines_t state_o,
    output logic [3:0] delta_o
);
    typedef struct packed {
        mdm_lines_t lines;
        logic [3:0] delta;
    } trk_t;

    trk_t d, q;
    logic [3:0] chg;

    always_comb begin
        chg[0] = lines_i.cts ^ q.lines.cts;
        chg[1] = lines_i.dsr ^ q.lines.dsr;
        chg[2] = q.lines.ri & ~lines_i.ri;   // trailing edge only
        chg[3] = lines_i.dcd ^ q.lines.dcd;
        d.lines = lines_i;
        d.delta = (clr_i ? 4'b0 : q.delta) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{lines: LINES_RST, delta: 4'b0};
        else        q <= d;
    end

    assign state_o = q.lines;
    assign delta_o = q.delta;

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((q.delta & $past(q.delta)) == $past(q.delta)));

    assert_no_teri_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.lines.ri && lines_i.ri && !q.delta[2]) |=> !q.delta[2]);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && lines_i == q.lines) |=> (q.delta == 4'b0));
endmodule

// File: rtl/mdm_ctl_status.sv
module mdm_ctl_status
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       stat_rd,
    output logic [7:0] stat_rdata,
    input  logic       irq_en,
    output logic       irq,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       dcd_i,
    input  logic       ri_i,
    output logic       rts_o,
    output logic       dtr_o,
    output logic       out1_o,
    output logic       out2_o
);
    localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1 << CTL_OUT2);

    logic [CTL_W-1:0] ctl;
    mdm_lines_t       raw_lines, sync_lines, state;
    logic [3:0]       delta;
    logic             loop;

    assign raw_lines = '{dcd: dcd_i, ri: ri_i, dsr: dsr_i, cts: cts_i};

    mdm_sync #(.N(LINE_N), .STAGES(SYNC_STAGES), .RST_VAL(LINES_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_lines), .sync_o(sync_lines)
    );

    mdm_ctl #(.W(CTL_W), .RST_VAL(CTL_RST)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_i(ctl_wr), .wdata_i(ctl_wdata), .ctl_o(ctl)
    );

    assign loop = ctl[CTL_LOOP];

    mdm_delta u_delta (
        .clk(clk), .rst_n(rst_n), .lines_i(sync_lines),
        .clr_i(stat_rd & ~loop), .state_o(state), .delta_o(delta)
    );

    always_comb begin
        ctl_rdata = {{(8-CTL_W){1'b0}}, ctl};
        if (loop)
            stat_rdata = {ctl[CTL_OUT2], ctl[CTL_OUT1], ctl[CTL_DTR], ctl[CTL_RTS], 4'b0};
        else
            stat_rdata = {state, delta};
        irq    = irq_en & (|delta);
        rts_o  = ctl[CTL_RTS] & ~loop;
        dtr_o  = ctl[CTL_DTR] & ~loop;
        out1_o = ctl[CTL_OUT1];
        out2_o = ctl[CTL_OUT2];
    end

    assert_ctl_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (ctl_rdata == {3'b0, $past(ctl_wdata[4:0])}));

    assert_irq_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && !loop && (stat_rdata[3:0] != 4'b0)) |-> irq);

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    assert_loop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[4] |-> (!rts_o && !dtr_o && stat_rdata[3:0] == 4'b0));
endmodule

// File: tb/tb_mdm_ctl_status.sv
module tb_mdm_ctl_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata, stat_rdata;
    logic stat_rd = 1'b0, irq_en = 1'b0, irq;
    logic cts_i = 1'b1, dsr_i = 1'b1, dcd_i = 1'b1, ri_i = 1'b0;
    logic rts_o, dtr_o, out1_o, out2_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mdm_ctl_status dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .irq_en(irq_en), .irq(irq), .cts_i(cts_i), .dsr_i(dsr_i),
        .dcd_i(dcd_i), .ri_i(ri_i), .rts_o(rts_o), .dtr_o(dtr_o),
        .out1_o(out1_o), .out2_o(out2_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        step(1);
        ctl_wr = 1'b0;
    endtask

    task automatic rd_stat();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(ctl_rdata, 8'h08, "R1 ctl reset");
        chk(stat_rdata, 8'hB0, "R1 status reset");
        chk({4'b0, irq, rts_o, dtr_o, out1_o}, 8'h00, "R1 irq/rts/dtr/out1");
        chk({7'b0, out2_o}, 8'h01, "R1 out2");
    endtask

    task automatic t_ctl_write();
        wr_ctl(8'hE7);
        chk(ctl_rdata, 8'h07, "R2 mask upper bits");
        chk({4'b0, dtr_o, rts_o, out1_o, out2_o}, 8'h0E, "R2 outputs 07");
        wr_ctl(8'h0B);
        chk({4'b0, dtr_o, rts_o, out1_o, out2_o}, 8'h0D, "R2 outputs 0B");
        wr_ctl(8'h08);
    endtask

    task automatic t_line_state();
        cts_i = 1'b0;
        step(2);
        chk(stat_rdata, 8'hB0, "R3 not visible after two edges");
        step(1);
        chk(stat_rdata, 8'hA1, "R3 visible on third edge, R4 dCTS");
        chk(stat_rdata, 8'hA1, "R6 value presented during read");
        rd_stat();
        chk(stat_rdata, 8'hA0, "R6 cleared after read");
    endtask

    task automatic t_deltas();
        dsr_i = 1'b0; dcd_i = 1'b0;
        step(3);
        chk(stat_rdata, 8'h0A, "R4 dDSR and dDCD");
        cts_i = 1'b1;
        step(3);
        chk(stat_rdata, 8'h1B, "R4 flags sticky plus dCTS");
        rd_stat();
        chk(stat_rdata, 8'h10, "R6 clear");
    endtask

    task automatic t_teri();
        ri_i = 1'b1;
        step(3);
        chk(stat_rdata, 8'h50, "R5 rising ring leaves flag clear");
        ri_i = 1'b0;
        step(3);
        chk(stat_rdata, 8'h14, "R5 falling ring sets flag");
        rd_stat();
        chk(stat_rdata, 8'h10, "R5 cleared by read");
    endtask

    task automatic t_race();
        cts_i = 1'b0;
        step(3);
        chk(stat_rdata, 8'h01, "R4 dCTS before race");
        dsr_i = 1'b1;
        step(2);
        rd_stat();
        chk(stat_rdata, 8'h22, "R6 same-cycle change kept");
        rd_stat();
        chk(stat_rdata, 8'h20, "R6 clear after race");
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        dcd_i = 1'b1;
        step(3);
        chk(stat_rdata, 8'hA8, "R4 dDCD");
        chk({7'b0, irq}, 8'h00, "R7 masked irq");
        irq_en = 1'b1;
        #1;
        chk({7'b0, irq}, 8'h01, "R7 irq enabled");
        @(negedge clk);
        rd_stat();
        chk({7'b0, irq}, 8'h00, "R7 irq drops after clear");
    endtask

    task automatic t_loop();
        wr_ctl(8'h1B);
        chk({4'b0, rts_o, dtr_o, out1_o, out2_o}, 8'h01, "R8 rts/dtr held low");
        chk(stat_rdata, 8'hB0, "R8 loop mapping 1B");
        cts_i = 1'b1;
        step(3);
        chk(stat_rdata, 8'hB0, "R8 deltas read zero in loop");
        rd_stat();
        wr_ctl(8'h08);
        chk(stat_rdata, 8'hB1, "R8 loop read did not clear");
        wr_ctl(8'h14);
        chk(stat_rdata, 8'h40, "R8 loop mapping OUT1 on bit 6");
        wr_ctl(8'h08);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ctl_write();
        t_line_state();
        t_deltas();
        t_teri();
        t_race();
        t_irq();
        t_loop();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule